// File: doc/BRIEF.md
# Two-Wire Master Control and Status Register Block

This block is the software-facing register file of a command-driven two-wire (I2C) master. Software programs two clock settings (one for standard/fast mode, one for high-speed mode), a bus configuration word, a target address and up to eight bytes of transmit data. It then writes a command word. That write raises a one-cycle start strobe toward the transfer engine and marks the block busy. The engine itself is outside this block. It sees only the decoded fields as plain outputs and reports the outcome through five event inputs.

Each event is latched into a sticky status bit. Software clears a status bit by writing a one to it. A level interrupt is raised whenever a latched status bit is also enabled in the mask register. A typical setup enables only the completion bit. At the end of a transfer, error flags such as lost arbitration or a missing acknowledge are latched next to the completion flag. Software therefore takes a single interrupt and can still read every flag. Software that does not use the interrupt can poll the busy register instead. Busy drops in the same clock edge that latches the completion flag.

The bus interface is a plain word-write port with combinational read data. Reads and writes complete in one cycle.

Top module: `twi_csr`

## Requirements
- R1: After a synchronous active-low reset, the registers read as follows. The standard and high-speed clock registers read 0x0000301F (filter 3 in bits 15:12, divider 0x01F in bits 9:0). The configuration register reads 0x00003302. Status, mask, busy, command, address and both data registers read 0. The irq, start_pulse and busy outputs are low.
- R2: Registers sit at byte offsets 0x00 (standard clock), 0x04 (high-speed clock), 0x08 (configuration), 0x0C (command), 0x10 (address), 0x14 (data low), 0x18 (data high), 0x1C (status), 0x20 (mask) and 0x24 (busy). Only the defined bits store a value. The clock registers keep bits 15:12 and 9:0, the configuration register keeps 0xFFF3, the command register keeps 0x377, the address register keeps 9:0, the data registers keep all 32 bits and the mask keeps 4:0.
- R3: The field outputs follow the stored bits. Clock register: filter 15:12, divider 9:0. Configuration: arbitration filter 15:12, NAK limit 11:8, 10-bit addressing 7, master code 6:4, arbitration enable 1, high-speed enable 0. Command: kind 9:8, write count 6:4, read count 2:0.
- R4: A write to offset 0x0C drives start_pulse high for exactly the next cycle and sets busy.
- R5: An event on evt_flags bit 0 (done) clears busy in the same edge that sets status bit 0. Register 0x24 reads busy in bit 0.
- R6: evt_flags bits 0..4 (done, lost arbitration, no acknowledge, data collision, bus busy) each set the status bit of the same index. Status bits stay set until cleared, whatever the event inputs do afterwards.
- R7: A write to offset 0x1C clears every status bit written as one and leaves the other bits unchanged.
- R8: If an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends set.
- R9: irq is high exactly when some status bit and the same mask bit are both set. The mask resets to 0.
- R10: Unmapped offsets and offsets not aligned to a word read as 0, and writes to them change nothing. The busy register is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for bus_addr/bus_wdata |
| bus_addr | input | ADDR_W | Byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| evt_flags | input | 5 | Engine events: 0 done, 1 lost arbitration, 2 no ack, 3 collision, 4 bus busy |
| irq | output | 1 | Level interrupt |
| start_pulse | output | 1 | One-cycle command start strobe |
| busy | output | 1 | Command in progress |
| std_filter | output | 4 | Standard/fast glitch filter |
| std_div | output | 10 | Standard/fast clock divider |
| hs_filter | output | 4 | High-speed glitch filter |
| hs_div | output | 10 | High-speed clock divider |
| arb_filter | output | 4 | Arbitration filter |
| nak_limit | output | 4 | NAK count |
| addr10_en | output | 1 | 10-bit addressing enable |
| master_code | output | 3 | High-speed master code |
| arb_en | output | 1 | Arbitration enable |
| hs_en | output | 1 | High-speed mode enable |
| xfer_kind | output | 2 | Command kind |
| wr_count | output | 3 | Write byte count field |
| rd_count | output | 3 | Read byte count field |
| target_addr | output | 10 | Slave address |
| tx_lo | output | 32 | Data low word |
| tx_hi | output | 32 | Data high word |

## Verification
The in-line assertions watch the status and busy logic on every cycle. A command write must produce a start strobe and set busy. A done event must drop busy and latch its flag. Any event must survive a clear written in the same cycle. Cleared bits must not reappear without an event, and irq must stay low while the mask is zero.

The bench scenarios cover what the assertions cannot. These are the reset readback values, the offset map and the keep masks, and the decoding of each field onto its output pins. They also include the error flags latching next to done while only done is unmasked, and writes to misaligned, unmapped or read-only offsets leaving every register untouched.

// File: rtl/twi_csr_pkg.sv
// Shared definitions for the two-wire master register block: register
// indices, event bit positions, reset values and per-register keep masks.
package twi_csr_pkg;

    localparam int DATA_W   = 32;
    localparam int EVT_N    = 5;
    localparam int NUM_REGS = 10;

    typedef enum logic [3:0] {
        RI_CLK_STD = 4'd0,
        RI_CLK_HS  = 4'd1,
        RI_CFG     = 4'd2,
        RI_CMD     = 4'd3,
        RI_ADDR    = 4'd4,
        RI_DLO     = 4'd5,
        RI_DHI     = 4'd6,
        RI_STS     = 4'd7,
        RI_MSK     = 4'd8,
        RI_BUSY    = 4'd9,
        RI_NONE    = 4'd15
    } reg_idx_e;

    localparam int EV_DONE = 0;

    localparam logic [DATA_W-1:0] CLK_RST   = 32'h0000_301F;
    localparam logic [DATA_W-1:0] CLK_KEEP  = 32'h0000_F3FF;
    localparam logic [DATA_W-1:0] CFG_RST   = 32'h0000_3302;
    localparam logic [DATA_W-1:0] CFG_KEEP  = 32'h0000_FFF3;
    localparam logic [DATA_W-1:0] CMD_KEEP  = 32'h0000_0377;
    localparam logic [DATA_W-1:0] ADDR_KEEP = 32'h0000_03FF;

    // Map a byte offset to a register index; misaligned or out-of-range gives RI_NONE.
    function automatic reg_idx_e decode_offset(input logic [31:0] off);
        if (off[1:0] != 2'b00 || off[31:2] >= 30'(NUM_REGS))
            return RI_NONE;
        return reg_idx_e'(off[5:2]);
    endfunction

endpackage

// File: rtl/twi_csr_regs.sv
// Plain read/write storage of the register block: two clock registers,
// configuration, command, address, two data words and the interrupt mask.
// Assumes wr_sel is one-hot or zero; each store keeps only its defined bits.
module twi_csr_regs
    import twi_csr_pkg::*;
#(
    parameter int NCLK  = 2,
    parameter int NDATA = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_REGS-1:0]            wr_sel,
    input  logic [DATA_W-1:0]              wdata,
    output logic [NCLK-1:0][DATA_W-1:0]    clk_q,
    output logic [DATA_W-1:0]              cfg_q,
    output logic [DATA_W-1:0]              cmd_q,
    output logic [DATA_W-1:0]              addr_q,
    output logic [NDATA-1:0][DATA_W-1:0]   data_q,
    output logic [EVT_N-1:0]               mask_q
);

    // Clock registers, one per speed class.
    for (genvar g = 0; g < NCLK; g++) begin : g_clk
        // Hold filter and divider for this speed class.
        always_ff @(posedge clk) begin
            if (!rst_n)
                clk_q[g] <= CLK_RST;
            else if (wr_sel[int'(RI_CLK_STD) + g])
                clk_q[g] <= wdata & CLK_KEEP;
        end
    end

    // Transmit data words.
    for (genvar g = 0; g < NDATA; g++) begin : g_data
        // Hold one 32-bit data word.
        always_ff @(posedge clk) begin
            if (!rst_n)
                data_q[g] <= '0;
            else if (wr_sel[int'(RI_DLO) + g])
                data_q[g] <= wdata;
        end
    end

    // Configuration, command, address and mask storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= CFG_RST;
            cmd_q  <= '0;
            addr_q <= '0;
            mask_q <= '0;
        end else begin
            if (wr_sel[RI_CFG])  cfg_q  <= wdata & CFG_KEEP;
            if (wr_sel[RI_CMD])  cmd_q  <= wdata & CMD_KEEP;
            if (wr_sel[RI_ADDR]) addr_q <= wdata & ADDR_KEEP;
            if (wr_sel[RI_MSK])  mask_q <= wdata[EVT_N-1:0];
        end
    end

endmodule

// File: rtl/twi_csr_events.sv
// Status, busy and interrupt logic. Latches engine events into sticky
// status bits with write-one-to-clear, where a set wins over a clear in
// the same cycle. Tracks busy from command write to done, raises a
// one-cycle start strobe and drives a level interrupt from status and mask.
module twi_csr_events
    import twi_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] evt,
    input  logic             sts_wr,
    input  logic [EVT_N-1:0] clr_bits,
    input  logic             cmd_wr,
    input  logic [EVT_N-1:0] mask,
    output logic [EVT_N-1:0] sts,
    output logic             busy,
    output logic             start,
    output logic             irq
);

    for (genvar i = 0; i < EVT_N; i++) begin : g_sts
        // Sticky status bit: event sets, write-one clears, set has priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                sts[i] <= 1'b0;
            else if (evt[i])
                sts[i] <= 1'b1;
            else if (sts_wr && clr_bits[i])
                sts[i] <= 1'b0;
        end
    end

    // Busy from command write until the done event; a new command wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (cmd_wr)
            busy <= 1'b1;
        else if (evt[EV_DONE])
            busy <= 1'b0;
    end

    // Start strobe lasts one cycle after each command write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            start <= 1'b0;
        else
            start <= cmd_wr;
    end

    // Level interrupt from enabled status bits.
    assign irq = |(sts & mask);

    AST_START_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> (start && busy)); // R4
    AST_START_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> $past(cmd_wr)); // R4
    AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[EV_DONE] && !cmd_wr) |=> (!busy && sts[EV_DONE])); // R5
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((sts & $past(evt)) == $past(evt))); // R8
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sts_wr |=> ((sts & $past(clr_bits & ~evt)) == '0)); // R7
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq); // R9

endmodule

// File: rtl/twi_csr.sv
// Top of the two-wire master register block. Decodes word offsets into
// one-hot write selects, assembles combinational read data and splits the
// stored words into engine-facing fields. Assumes one access per cycle.
module twi_csr
    import twi_csr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [4:0]        evt_flags,
    output logic              irq,
    output logic              start_pulse,
    output logic              busy,
    output logic [3:0]        std_filter,
    output logic [9:0]        std_div,
    output logic [3:0]        hs_filter,
    output logic [9:0]        hs_div,
    output logic [3:0]        arb_filter,
    output logic [3:0]        nak_limit,
    output logic              addr10_en,
    output logic [2:0]        master_code,
    output logic              arb_en,
    output logic              hs_en,
    output logic [1:0]        xfer_kind,
    output logic [2:0]        wr_count,
    output logic [2:0]        rd_count,
    output logic [9:0]        target_addr,
    output logic [31:0]       tx_lo,
    output logic [31:0]       tx_hi
);

    localparam int NCLK  = 2;
    localparam int NDATA = 2;

    reg_idx_e                     idx;
    logic [NUM_REGS-1:0]          wr_sel;
    logic [NCLK-1:0][DATA_W-1:0]  clk_q;
    logic [NDATA-1:0][DATA_W-1:0] data_q;
    logic [DATA_W-1:0]            cfg_q, cmd_q, addr_q;
    logic [EVT_N-1:0]             mask_q, sts_q;

    // Offset decode shared by read and write paths.
    assign idx = decode_offset(32'(bus_addr));

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        assign wr_sel[i] = bus_wr && (idx == reg_idx_e'(4'(i)));
    end

    twi_csr_regs #(.NCLK(NCLK), .NDATA(NDATA)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (wr_sel),
        .wdata  (bus_wdata),
        .clk_q  (clk_q),
        .cfg_q  (cfg_q),
        .cmd_q  (cmd_q),
        .addr_q (addr_q),
        .data_q (data_q),
        .mask_q (mask_q)
    );

    twi_csr_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_flags),
        .sts_wr   (wr_sel[RI_STS]),
        .clr_bits (bus_wdata[EVT_N-1:0]),
        .cmd_wr   (wr_sel[RI_CMD]),
        .mask     (mask_q),
        .sts      (sts_q),
        .busy     (busy),
        .start    (start_pulse),
        .irq      (irq)
    );

    // Read mux: unmapped offsets return zero.
    always_comb begin
        unique case (idx)
            RI_CLK_STD: bus_rdata = clk_q[0];
            RI_CLK_HS:  bus_rdata = clk_q[1];
            RI_CFG:     bus_rdata = cfg_q;
            RI_CMD:     bus_rdata = cmd_q;
            RI_ADDR:    bus_rdata = addr_q;
            RI_DLO:     bus_rdata = data_q[0];
            RI_DHI:     bus_rdata = data_q[1];
            RI_STS:     bus_rdata = 32'(sts_q);
            RI_MSK:     bus_rdata = 32'(mask_q);
            RI_BUSY:    bus_rdata = 32'(busy);
            default:    bus_rdata = '0;
        endcase
    end

    // Field split toward the transfer engine.
    assign std_filter  = clk_q[0][15:12];
    assign std_div     = clk_q[0][9:0];
    assign hs_filter   = clk_q[1][15:12];
    assign hs_div      = clk_q[1][9:0];
    assign arb_filter  = cfg_q[15:12];
    assign nak_limit   = cfg_q[11:8];
    assign addr10_en   = cfg_q[7];
    assign master_code = cfg_q[6:4];
    assign arb_en      = cfg_q[1];
    assign hs_en       = cfg_q[0];
    assign xfer_kind   = cmd_q[9:8];
    assign wr_count    = cmd_q[6:4];
    assign rd_count    = cmd_q[2:0];
    assign target_addr = addr_q[9:0];
    assign tx_lo       = data_q[0];
    assign tx_hi       = data_q[1];

    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx == RI_BUSY && !busy && evt_flags == '0) |=> (!busy && !start_pulse)); // R10

endmodule

// File: tb/test_twi_csr.sv
// Directed bench for twi_csr: one task per scenario, each checking itself.
module test_twi_csr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  evt_flags = '0;
    logic        irq, start_pulse, busy;
    logic [3:0]  std_filter, hs_filter, arb_filter, nak_limit;
    logic [9:0]  std_div, hs_div, target_addr;
    logic        addr10_en, arb_en, hs_en;
    logic [2:0]  master_code, wr_count, rd_count;
    logic [1:0]  xfer_kind;
    logic [31:0] tx_lo, tx_hi;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] rv;

    always #5 clk = ~clk;

    twi_csr i_twi_csr (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_flags(evt_flags),
        .irq(irq), .start_pulse(start_pulse), .busy(busy),
        .std_filter(std_filter), .std_div(std_div), .hs_filter(hs_filter),
        .hs_div(hs_div), .arb_filter(arb_filter), .nak_limit(nak_limit),
        .addr10_en(addr10_en), .master_code(master_code), .arb_en(arb_en),
        .hs_en(hs_en), .xfer_kind(xfer_kind), .wr_count(wr_count),
        .rd_count(rd_count), .target_addr(target_addr), .tx_lo(tx_lo), .tx_hi(tx_hi)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input logic [4:0] e);
        @(negedge clk);
        evt_flags = e;
        @(negedge clk);
        evt_flags = '0;
    endtask

    // R1: reset values of every register and output.
    task automatic t_reset();
        logic [31:0] exp [10];
        exp = '{32'h301F, 32'h301F, 32'h3302, 0, 0, 0, 0, 0, 0, 0};
        for (int i = 0; i < 10; i++) begin
            rd(8'(i * 4), rv);
            check($sformatf("R1 reg 0x%02h", i * 4), rv, exp[i]);
        end
        check("R1 irq/start/busy", {29'b0, irq, start_pulse, busy}, 32'h0);
    endtask

    // R2/R3: keep masks, offset map and field outputs.
    task automatic t_map();
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, rv); check("R2 std clk keep", rv, 32'hF3FF);
        wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, rv); check("R2 cfg keep", rv, 32'hFFF3);
        wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, rv); check("R2 addr keep", rv, 32'h03FF);
        wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, rv); check("R2 mask keep", rv, 32'h1F);
        wr(8'h20, 32'h0);
        wr(8'h00, 32'h0000_7123);
        wr(8'h04, 32'h0000_C0AA);
        wr(8'h08, 32'h0000_A5C3);
        wr(8'h10, 32'h0001_2345);
        wr(8'h14, 32'hDEAD_BEEF);
        wr(8'h18, 32'h0BAD_F00D);
        rd(8'h04, rv); check("R2 hs clk", rv, 32'hC0AA);
        rd(8'h18, rv); check("R2 data hi", rv, 32'h0BAD_F00D);
        check("R3 std fields", {18'b0, std_filter, std_div}, {18'b0, 4'h7, 10'h123});
        check("R3 hs fields", {18'b0, hs_filter, hs_div}, {18'b0, 4'hC, 10'h0AA});
        check("R3 cfg fields", {17'b0, arb_filter, nak_limit, addr10_en, master_code, arb_en, hs_en},
              {17'b0, 4'hA, 4'h5, 1'b1, 3'h4, 1'b1, 1'b1});
        check("R3 target addr", 32'(target_addr), 32'h345);
        check("R3 tx_lo", tx_lo, 32'hDEAD_BEEF);
        check("R3 tx_hi", tx_hi, 32'h0BAD_F00D);
    endtask

    // R4: command write gives one start cycle and sets busy.
    task automatic t_start();
        wr(8'h0C, 32'hFFFF_F215);
        check("R4 start high", 32'(start_pulse), 32'h1);
        check("R4 busy set", 32'(busy), 32'h1);
        check("R3 cmd fields", {24'b0, xfer_kind, wr_count, rd_count}, {24'b0, 2'd2, 3'd1, 3'd5});
        @(negedge clk);
        check("R4 start one cycle", 32'(start_pulse), 32'h0);
        rd(8'h24, rv); check("R4 busy reg", rv, 32'h1);
        rd(8'h0C, rv); check("R2 cmd keep", rv, 32'h215);
    endtask

    // R5/R9: done clears busy, latches bit 0, raises unmasked irq; W1C clears.
    task automatic t_done();
        wr(8'h20, 32'h1);
        check("R9 irq before done", 32'(irq), 32'h0);
        pulse(5'h01);
        check("R5 busy cleared", 32'(busy), 32'h0);
        rd(8'h1C, rv); check("R5 done status", rv, 32'h01);
        rd(8'h24, rv); check("R5 busy reg clear", rv, 32'h0);
        check("R9 irq on done", 32'(irq), 32'h1);
        wr(8'h1C, 32'h1);
        rd(8'h1C, rv); check("R7 done cleared", rv, 32'h0);
        check("R9 irq dropped", 32'(irq), 32'h0);
    endtask

    // R6/R7/R9: error flags latch beside done with only done unmasked.
    task automatic t_errors();
        pulse(5'h02);
        rd(8'h1C, rv); check("R6 lost arb latched", rv, 32'h02);
        check("R9 masked error no irq", 32'(irq), 32'h0);
        pulse(5'h0C);
        rd(8'h1C, rv); check("R6 noack+collision", rv, 32'h0E);
        pulse(5'h01);
        rd(8'h1C, rv); check("R6 done beside errors", rv, 32'h0F);
        check("R9 irq from done", 32'(irq), 32'h1);
        pulse(5'h10);
        rd(8'h1C, rv); check("R6 bus busy", rv, 32'h1F);
        wr(8'h1C, 32'h06);
        rd(8'h1C, rv); check("R7 partial clear", rv, 32'h19);
        wr(8'h1C, 32'h19);
        rd(8'h1C, rv); check("R7 full clear", rv, 32'h0);
    endtask

    // R8: set wins over clear in the same cycle.
    task automatic t_priority();
        pulse(5'h04);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h1C; bus_wdata = 32'h0C; evt_flags = 5'h08;
        @(negedge clk);
        bus_wr = 1'b0; evt_flags = '0;
        rd(8'h1C, rv); check("R8 set beats clear", rv, 32'h08);
        wr(8'h1C, 32'h1F);
        rd(8'h1C, rv); check("R7 clear after race", rv, 32'h0);
    endtask

    // R9: mask gates the interrupt.
    task automatic t_mask();
        wr(8'h20, 32'h1F);
        pulse(5'h10);
        check("R9 irq bit4 enabled", 32'(irq), 32'h1);
        wr(8'h20, 32'h0F);
        check("R9 irq bit4 masked", 32'(irq), 32'h0);
        rd(8'h1C, rv); check("R9 status kept", rv, 32'h10);
        wr(8'h1C, 32'h10);
        wr(8'h20, 32'h0);
    endtask

    // R10: unmapped/misaligned offsets and read-only busy.
    task automatic t_unmapped();
        rd(8'h28, rv); check("R10 unmapped read", rv, 32'h0);
        rd(8'hFC, rv); check("R10 high read", rv, 32'h0);
        wr(8'h0A, 32'h0);
        rd(8'h08, rv); check("R10 misaligned write", rv, 32'hA5C3);
        wr(8'h0D, 32'h1);
        check("R10 misaligned cmd no start", 32'(start_pulse), 32'h0);
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h28, rv); check("R10 unmapped write", rv, 32'h0);
        wr(8'h24, 32'h1);
        check("R10 busy port", {30'b0, busy, start_pulse}, 32'h0);
        rd(8'h24, rv); check("R10 busy read-only", rv, 32'h0);
    endtask

    initial begin
        #500000;
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_start();
        t_done();
        t_errors();
        t_priority();
        t_mask();
        t_unmapped();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule